// File: doc/BRIEF.md
# Hashed Page Table Group Index Generator

This block turns a translation request into the group indices of a hashed page table. Each request carries an effective address, a virtual segment identifier, a two-bit segment-size code and the base-2 logarithm of the page size. The block forms a virtual page number with the twelve lowest address bits dropped. It then folds the segment identifier into the in-segment page index using a rule chosen by the segment size, and keeps 39 bits of the result.

A table mask, supplied with each request, reduces the 39-bit hash to the index of the primary group. The complemented hash under the same mask gives the secondary group. Requests enter through a valid/ready handshake. Results leave through one register stage that holds its contents while the consumer stalls. A request with a reserved segment-size code produces no result. It pulses an error flag instead.

Top module: `hpt_hash_gen`

## Requirements
- R1: After reset, outValid and errFlag are 0 and inReady is 1.
- R2: With segSize code 0 (256 MB segments, segment shift 28), hashOut = (vsid XOR (ea[27:12] >> (p-12))) truncated to 39 bits, where p is the effective page shift.
- R3: With segSize code 1 (1 TB segments, segment shift 40), hashOut = (vsid XOR (vsid << 25) XOR (ea[39:12] >> (p-12))) truncated to 39 bits.
- R4: The effective page shift p equals pageShift, except that a pageShift below 12 is treated as 12. A page shift at or beyond the segment shift reduces the page term to zero.
- R5: priIdx = hashOut AND tableMask, and secIdx = (NOT hashOut) AND tableMask, using the tableMask presented with the request.
- R6: A request with a valid segment code that is accepted on a clock edge (inValid and inReady both 1) appears with outValid = 1 right after that edge.
- R7: While outValid = 1 and outReady = 0, inReady is 0 and outValid, hashOut, priIdx and secIdx all hold their values.
- R8: An accepted request with segSize code 2 or 3 does not set outValid. It raises errFlag for exactly the one cycle after acceptance.
- R9: When outReady is 1, inReady is 1, so one request can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken |
| ea | input | 64 | Effective address |
| vsid | input | 40 | Virtual segment identifier |
| segSize | input | 2 | Segment size: 0 = 256 MB, 1 = 1 TB, 2 and 3 reserved |
| pageShift | input | 6 | Base-2 log of the page size |
| tableMask | input | 39 | Mask that selects the group index bits |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| hashOut | output | 39 | Primary hash |
| priIdx | output | 39 | Primary group index |
| secIdx | output | 39 | Secondary group index |
| errFlag | output | 1 | One-cycle pulse after a reserved segment code is accepted |

## Verification
The vector table includes both segment sizes with 4 KB, 64 KB, 16 MB and 16 GB pages. Comparing the two sizes at the same page shift shows whether the segment-size select and the 25-bit self-fold are both correct. Vectors with a page shift below 12 and with page shifts at or past the segment shift separate the clamping path from the case where the page term becomes zero. Narrow and full table masks separate the primary and secondary index paths. Directed sequences cover a stall with a waiting request, reserved codes arriving when the stage is empty and while it is draining, and back-to-back acceptance.

// File: rtl/hpt_hash_pkg.sv
package hpt_hash_pkg;
  typedef enum logic [1:0] {
    SEG_SMALL = 2'd0,
    SEG_LARGE = 2'd1,
    SEG_RSV2  = 2'd2,
    SEG_RSV3  = 2'd3
  } segCode_t;

  typedef struct packed {
    logic load;
    logic flagErr;
  } stageCtl_t;
endpackage

// File: rtl/hpt_hash_dp.sv
module hpt_hash_dp
  import hpt_hash_pkg::*;
#(
  parameter int EA_W = 64,
  parameter int VSID_W = 40,
  parameter int HASH_W = 39,
  parameter int PS_W = 6,
  parameter int SMALL_SEG_SHIFT = 28,
  parameter int LARGE_SEG_SHIFT = 40,
  parameter int PAGE_MIN = 12,
  parameter int FOLD_SHIFT = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtl_t         ctl,
  input  logic [EA_W-1:0]   ea,
  input  logic [VSID_W-1:0] vsid,
  input  logic [1:0]        segSize,
  input  logic [PS_W-1:0]   pageShift,
  input  logic [HASH_W-1:0] tableMask,
  output logic [HASH_W-1:0] hashQ,
  output logic [HASH_W-1:0] priQ,
  output logic [HASH_W-1:0] secQ
);
  localparam int SMALL_BITS = SMALL_SEG_SHIFT - PAGE_MIN;
  localparam int LARGE_BITS = LARGE_SEG_SHIFT - PAGE_MIN;
  localparam int ACC_W = VSID_W + HASH_W;

  logic [LARGE_BITS-1:0] segLow;
  logic [LARGE_BITS-1:0] pageTerm;
  logic [PS_W-1:0]       shAmt;
  logic [ACC_W-1:0]      idWide;
  logic [ACC_W-1:0]      idFold;
  logic [HASH_W-1:0]     hashD;

  always_comb begin
    if (segSize == SEG_LARGE)
      segLow = ea[LARGE_SEG_SHIFT-1:PAGE_MIN];
    else
      segLow = LARGE_BITS'(ea[SMALL_SEG_SHIFT-1:PAGE_MIN]);
    shAmt = (pageShift < PS_W'(PAGE_MIN)) ? '0 : pageShift - PS_W'(PAGE_MIN);
    pageTerm = segLow >> shAmt;
    idWide = ACC_W'(vsid);
    idFold = (segSize == SEG_LARGE) ? (idWide ^ (idWide << FOLD_SHIFT)) : idWide;
    hashD = idFold[HASH_W-1:0] ^ HASH_W'(pageTerm);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hashQ <= '0;
      priQ  <= '0;
      secQ  <= '0;
    end else if (ctl.load) begin
      hashQ <= hashD;
      priQ  <= hashD & tableMask;
      secQ  <= ~hashD & tableMask;
    end
  end

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(hashQ) && $stable(priQ) && $stable(secQ)));
endmodule

// File: rtl/hpt_hash_ctrl.sv
module hpt_hash_ctrl
  import hpt_hash_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [1:0] segSize,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output logic      errFlag,
  output stageCtl_t ctl
);
  logic accept;
  logic reservedCode;

  assign reservedCode = (segSize == SEG_RSV2) || (segSize == SEG_RSV3);
  assign inReady = !outValid || outReady;
  assign accept = inValid && inReady;

  always_comb begin
    ctl.load    = accept && !reservedCode;
    ctl.flagErr = accept && reservedCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      errFlag <= ctl.flagErr;
      if (ctl.load)
        outValid <= 1'b1;
      else if (outReady)
        outValid <= 1'b0;
    end
  end

  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !segSize[1]) |=> outValid);
  // R7
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
  // R8
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !outValid);
  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && segSize[1]) |=> errFlag);
endmodule

// File: rtl/hpt_hash_gen.sv
module hpt_hash_gen
  import hpt_hash_pkg::*;
#(
  parameter int EA_W = 64,
  parameter int VSID_W = 40,
  parameter int HASH_W = 39,
  parameter int PS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [EA_W-1:0]   ea,
  input  logic [VSID_W-1:0] vsid,
  input  logic [1:0]        segSize,
  input  logic [PS_W-1:0]   pageShift,
  input  logic [HASH_W-1:0] tableMask,
  output logic              outValid,
  input  logic              outReady,
  output logic [HASH_W-1:0] hashOut,
  output logic [HASH_W-1:0] priIdx,
  output logic [HASH_W-1:0] secIdx,
  output logic              errFlag
);
  stageCtl_t ctl;

  hpt_hash_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .segSize(segSize),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .errFlag(errFlag), .ctl(ctl)
  );

  hpt_hash_dp #(
    .EA_W(EA_W), .VSID_W(VSID_W), .HASH_W(HASH_W), .PS_W(PS_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ea(ea), .vsid(vsid),
    .segSize(segSize), .pageShift(pageShift), .tableMask(tableMask),
    .hashQ(hashOut), .priQ(priIdx), .secQ(secIdx)
  );
endmodule

// File: tb/hpt_hash_gen_tb_top.sv
module hpt_hash_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] ea = '0;
  logic [39:0] vsid = '0;
  logic [1:0]  segSize = '0;
  logic [5:0]  pageShift = 6'd12;
  logic [38:0] tableMask = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [38:0] hashOut, priIdx, secIdx;
  logic        errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hpt_hash_gen dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .ea(ea),
    .vsid(vsid), .segSize(segSize), .pageShift(pageShift), .tableMask(tableMask),
    .outValid(outValid), .outReady(outReady), .hashOut(hashOut),
    .priIdx(priIdx), .secIdx(secIdx), .errFlag(errFlag)
  );

  // fields: ea(64) vsid(40) segSize(2) pageShift(6) tableMask(39)
  localparam int NV = 10;
  localparam logic [150:0] VEC [NV] = '{
    {64'h0000_0000_1234_5000, 40'h12_3456_789A, 2'd0, 6'd12, 39'h7F_FFFF_FFFF},
    {64'h0000_0000_0FFF_F000, 40'hFF_FFFF_FFFF, 2'd0, 6'd16, 39'h00_0000_07FF},
    {64'h0000_00AB_CDEF_1000, 40'h00_0000_0001, 2'd1, 6'd12, 39'h7F_FFFF_FFFF},
    {64'h0000_00FF_FFFF_F000, 40'h5A_5A5A_5A5A, 2'd1, 6'd24, 39'h00_000F_FFFF},
    {64'h0000_0000_0ABC_D000, 40'h00_0000_1234, 2'd0, 6'd5,  39'h00_0000_FFFF},
    {64'h0000_0000_0ABC_D000, 40'h00_0000_1234, 2'd0, 6'd28, 39'h7F_FFFF_FFFF},
    {64'h0000_0034_5678_9000, 40'hC3_C3C3_C3C3, 2'd1, 6'd34, 39'h0F_FFFF_FFFF},
    {64'h0000_0034_5678_9000, 40'hC3_C3C3_C3C3, 2'd1, 6'd40, 39'h7F_FFFF_FFFF},
    {64'hFFFF_FFFF_FFFF_FFFF, 40'h00_0000_0000, 2'd1, 6'd16, 39'h00_0000_FF00},
    {64'hFFFF_FFFF_FFFF_FFFF, 40'h80_0000_0001, 2'd0, 6'd63, 39'h55_5555_5555}
  };

  function automatic logic [38:0] refHash(logic [63:0] a, logic [39:0] v,
                                          logic [1:0] s, logic [5:0] p);
    int segBits;
    int eff;
    logic [127:0] vpn, id, low, pg, h;
    segBits = (s == 2'd0) ? 16 : 28;
    eff = (p < 6'd12) ? 12 : int'(p);
    vpn = ({88'b0, v} << segBits) | (({64'b0, a} >> 12) & ((128'b1 << segBits) - 128'b1));
    id = vpn >> segBits;
    low = vpn & ((128'b1 << segBits) - 128'b1);
    pg = low >> (eff - 12);
    h = (s == 2'd0) ? (id ^ pg) : (id ^ (id << 25) ^ pg);
    return h[38:0];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [150:0] v);
    {ea, vsid, segSize, pageShift, tableMask} = v;
    inValid = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [38:0] h, hA, hB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 outValid", 64'(outValid), 64'd0);
    check("R1 errFlag", 64'(errFlag), 64'd0);
    check("R1 inReady", 64'(inReady), 64'd1);

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      h = refHash(ea, vsid, segSize, pageShift);
      @(negedge clk);
      inValid = 1'b0;
      check("R6 outValid", 64'(outValid), 64'd1);
      check(segSize == 2'd0 ? "R2 R4 hash" : "R3 R4 hash", 64'(hashOut), 64'(h));
      check("R5 priIdx", 64'(priIdx), 64'(h & tableMask));
      check("R5 secIdx", 64'(secIdx), 64'(~h & tableMask));
      @(negedge clk);
    end

    // R7 back-pressure
    outReady = 1'b0;
    drive(VEC[2]);
    hA = refHash(ea, vsid, segSize, pageShift);
    @(negedge clk);
    drive(VEC[3]);
    hB = refHash(ea, vsid, segSize, pageShift);
    check("R7 inReady low", 64'(inReady), 64'd0);
    @(negedge clk);
    @(negedge clk);
    check("R7 valid held", 64'(outValid), 64'd1);
    check("R7 hash held", 64'(hashOut), 64'(hA));
    check("R7 inReady low", 64'(inReady), 64'd0);
    outReady = 1'b1;
    // R9 ready follows outReady
    #0.1 check("R9 inReady", 64'(inReady), 64'd1);
    @(negedge clk);
    inValid = 1'b0;
    check("R7 next request", 64'(hashOut), 64'(hB));
    @(negedge clk);
    check("R6 drained", 64'(outValid), 64'd0);

    // R8 reserved code on empty stage
    drive(VEC[0]);
    segSize = 2'd2;
    @(negedge clk);
    inValid = 1'b0;
    check("R8 errFlag", 64'(errFlag), 64'd1);
    check("R8 no valid", 64'(outValid), 64'd0);
    @(negedge clk);
    check("R8 errFlag one cycle", 64'(errFlag), 64'd0);

    // R9 back-to-back, then R8 reserved while draining
    drive(VEC[4]);
    hA = refHash(ea, vsid, segSize, pageShift);
    @(negedge clk);
    drive(VEC[6]);
    hB = refHash(ea, vsid, segSize, pageShift);
    check("R9 first", 64'(hashOut), 64'(hA));
    check("R9 inReady", 64'(inReady), 64'd1);
    @(negedge clk);
    check("R9 second", 64'(hashOut), 64'(hB));
    check("R9 valid", 64'(outValid), 64'd1);
    drive(VEC[1]);
    segSize = 2'd3;
    @(negedge clk);
    inValid = 1'b0;
    check("R8 code3 errFlag", 64'(errFlag), 64'd1);
    check("R8 code3 valid dropped", 64'(outValid), 64'd0);
    @(negedge clk);
    check("R8 code3 pulse end", 64'(errFlag), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule